// File: doc/BRIEF.md
# Seconds and Milliseconds Real-Time Clock with Alarm

This block is a real-time clock for a system bus. A one-cycle enable pulse, given once per period of a 32.768 kHz timebase, drives a 32-bit seconds counter and a milliseconds counter that runs from 0 to 999. One millisecond is 32.768 slow ticks. A fractional accumulator produces that rate, so exactly 1000 milliseconds pass in every 32768 ticks.

Software does not read the running counters. It sees a copy that is refreshed once every eight slow ticks. A busy flag is high during the tick interval just before each refresh, and software is expected to write the seconds value only while that flag is low. Reading milliseconds captures the copied seconds value into a shadow register, so a milliseconds read followed by a shadow read returns one coherent time stamp.

A seconds alarm compares its value with the running seconds. It raises a sticky status bit, which software clears by writing a one to it, and it drives a level-high interrupt when the matching mask bit is set.

Top module: `rtc_sec_ms`

## Requirements
- R1: After reset every register reads zero (busy 0x004, seconds 0x008, shadow 0x00C, milliseconds 0x010, alarm 0x014, mask 0x028, status 0x02C), and irq_o is low.
- R2: After a seconds load, N ticks give a total of floor(N*1000/32768) milliseconds. The milliseconds value wraps from 999 to 0, and each wrap adds one to seconds.
- R3: Seconds (0x008) and milliseconds (0x010) read a copy of the running counters. The copy is taken at each tick whose count since reset is a multiple of 8, and it holds the values that were present before that tick.
- R4: Bit 0 of the busy register (0x004) is 1 exactly while the tick count since reset, modulo 8, equals 7.
- R5: A write to seconds (0x008) while busy is low loads the counter, clears milliseconds and the fractional accumulator, and updates the bus copy at once.
- R6: A write to seconds while busy is high is ignored.
- R7: A read of milliseconds latches the copied seconds into the shadow register (0x00C). Writes to seconds do not change the shadow register.
- R8: Status bit 0 (0x02C) is set on the cycle after the running seconds first equals a nonzero alarm value (0x014). An alarm value of zero never sets it. While the match persists after a clear, the bit is not set again.
- R9: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. A set bit stays set whatever the mask holds.
- R10: irq_o is high one cycle after (status AND mask, 0x028) becomes nonzero, and it falls one cycle after that term becomes zero. Bit 0 of both registers is the seconds alarm.
- R11: bus_rdata is registered. It is loaded on the clock edge at which bus_rd is high, and it holds its value between reads. Unmapped offsets, including 0x018, read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle enable per 32.768 kHz period |
| bus_rd | input | 1 | Read strobe |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The hardest situation to reach from the ports is the alarm match. It needs the running seconds to reach the alarm value, which takes a full 32768 ticks, and the bench has to see the status bit in the exact cycle it sets. The bench drives tick_i itself and holds it low while it uses the bus, so the counters and the busy phase are frozen whenever the bus is in use. It runs 32767 ticks, checks that status is still clear, and then gives the final tick. An ignored seconds write is reached the same way: the bench stops the ticks with the phase counter at 7, so busy is high, and then issues the write.

// File: rtl/rtc_sec_ms_pkg.sv
package rtc_sec_ms_pkg;
  localparam logic [7:0] OFF_BUSY   = 8'h04;
  localparam logic [7:0] OFF_SEC    = 8'h08;
  localparam logic [7:0] OFF_SHADOW = 8'h0C;
  localparam logic [7:0] OFF_MS     = 8'h10;
  localparam logic [7:0] OFF_ALARM  = 8'h14;
  localparam logic [7:0] OFF_MASK   = 8'h28;
  localparam logic [7:0] OFF_STAT   = 8'h2C;
  localparam int IRQ_W    = 5;
  localparam int IRQ_ALM0 = 0;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int MS_PER_SEC    = 1000,
  parameter int SEC_W         = 32,
  localparam int MS_W  = $clog2(MS_PER_SEC),
  localparam int ACC_W = $clog2(TICKS_PER_SEC) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [SEC_W-1:0] load_sec,
  output logic [SEC_W-1:0] sec_o,
  output logic [MS_W-1:0]  ms_o
);
  localparam logic [MS_W-1:0]  MS_MAX = MS_W'(MS_PER_SEC - 1);
  localparam logic [ACC_W-1:0] ACC_LIM = ACC_W'(TICKS_PER_SEC);
  localparam logic [ACC_W-1:0] ACC_INC = ACC_W'(MS_PER_SEC);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_sum;
  logic             ms_step;
  logic             ms_wrap;

  always_comb begin
    acc_sum = acc + ACC_INC;
    ms_step = tick && (acc_sum >= ACC_LIM);
    ms_wrap = (ms_o == MS_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      ms_o  <= '0;
      sec_o <= '0;
    end else if (load) begin
      acc   <= '0;
      ms_o  <= '0;
      sec_o <= load_sec;
    end else if (tick) begin
      acc <= ms_step ? (acc_sum - ACC_LIM) : acc_sum;
      if (ms_step) begin
        if (ms_wrap) begin
          ms_o  <= '0;
          sec_o <= sec_o + 1'b1;
        end else begin
          ms_o <= ms_o + 1'b1;
        end
      end
    end
  end

  AST_MS_RANGE: assert property (@(posedge clk) disable iff (rst)
    ms_o <= MS_MAX); // R2
  AST_SEC_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!load && ms_step && ms_wrap) |=> (ms_o == '0 && sec_o == $past(sec_o) + 1'b1)); // R2
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    load |=> (ms_o == '0 && sec_o == $past(load_sec))); // R5
endmodule

// File: rtl/rtc_bus_copy.sv
module rtc_bus_copy #(
  parameter int SEC_W      = 32,
  parameter int MS_W       = 10,
  parameter int COPY_TICKS = 8,
  localparam int PH_W = $clog2(COPY_TICKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [SEC_W-1:0] load_sec,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [MS_W-1:0]  ms_i,
  input  logic             ms_rd,
  output logic             busy_o,
  output logic [SEC_W-1:0] bus_sec_o,
  output logic [MS_W-1:0]  bus_ms_o,
  output logic [SEC_W-1:0] shadow_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(COPY_TICKS - 1);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] phase_nxt;
  logic            at_last;

  always_comb begin
    at_last   = (phase == PH_LAST);
    phase_nxt = at_last ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      busy_o    <= 1'b0;
      bus_sec_o <= '0;
      bus_ms_o  <= '0;
      shadow_o  <= '0;
    end else begin
      if (tick) begin
        phase  <= phase_nxt;
        busy_o <= (phase_nxt == PH_LAST);
        if (at_last) begin
          bus_sec_o <= sec_i;
          bus_ms_o  <= ms_i;
        end
      end
      if (load) begin
        bus_sec_o <= load_sec;
        bus_ms_o  <= '0;
      end
      if (ms_rd) begin
        shadow_o <= bus_sec_o;
      end
    end
  end

  AST_COPY_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> ($stable(bus_sec_o) && $stable(bus_ms_o))); // R3
  AST_BUSY_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
    (busy_o && tick) |=> !busy_o); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ms_rd |=> $stable(shadow_o)); // R7
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_sec_ms_pkg::*;
#(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             alarm_we,
  input  logic [SEC_W-1:0] alarm_wdata,
  input  logic             mask_we,
  input  logic             stat_we,
  input  logic [IRQ_W-1:0] bits_wdata,
  output logic [SEC_W-1:0] alarm_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic [IRQ_W-1:0] status_o,
  output logic             irq_o
);
  logic             match;
  logic             match_q;
  logic [IRQ_W-1:0] stat_clr;
  logic [IRQ_W-1:0] status_nxt;

  always_comb begin
    match      = (alarm_o != '0) && (sec_i == alarm_o);
    stat_clr   = stat_we ? bits_wdata : '0;
    status_nxt = status_o & ~stat_clr;
    if (match && !match_q) status_nxt[IRQ_ALM0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_o  <= '0;
      mask_o   <= '0;
      status_o <= '0;
      match_q  <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      if (alarm_we) alarm_o <= alarm_wdata;
      if (mask_we)  mask_o  <= bits_wdata;
      status_o <= status_nxt;
      match_q  <= match;
      irq_o    <= |(status_o & mask_o);
    end
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status_o[IRQ_ALM0] && !(stat_we && bits_wdata[IRQ_ALM0])) |=> status_o[IRQ_ALM0]); // R9
  AST_ZERO_ALARM_OFF: assert property (@(posedge clk) disable iff (rst)
    (alarm_o == '0 && !status_o[IRQ_ALM0]) |=> !status_o[IRQ_ALM0]); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mask_o == '0) |=> !irq_o); // R10
endmodule

// File: rtl/rtc_sec_ms.sv
module rtc_sec_ms
  import rtc_sec_ms_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int TICKS_PER_SEC = 32768,
  parameter int MS_PER_SEC    = 1000,
  parameter int COPY_TICKS    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              bus_rd,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int SEC_W = DATA_W;
  localparam int MS_W  = $clog2(MS_PER_SEC);

  logic hit_busy, hit_sec, hit_shadow, hit_ms, hit_alarm, hit_mask, hit_stat;
  logic sec_load;
  logic ms_rd;
  logic busy;
  logic [SEC_W-1:0] run_sec, bus_sec, shadow_sec, alarm_val;
  logic [MS_W-1:0]  run_ms, bus_ms;
  logic [IRQ_W-1:0] mask_val, stat_val;
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    hit_busy   = (bus_addr == ADDR_W'(OFF_BUSY));
    hit_sec    = (bus_addr == ADDR_W'(OFF_SEC));
    hit_shadow = (bus_addr == ADDR_W'(OFF_SHADOW));
    hit_ms     = (bus_addr == ADDR_W'(OFF_MS));
    hit_alarm  = (bus_addr == ADDR_W'(OFF_ALARM));
    hit_mask   = (bus_addr == ADDR_W'(OFF_MASK));
    hit_stat   = (bus_addr == ADDR_W'(OFF_STAT));
    sec_load   = bus_we && hit_sec && !busy;
    ms_rd      = bus_rd && hit_ms;
  end

  rtc_timebase #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .MS_PER_SEC   (MS_PER_SEC),
    .SEC_W        (SEC_W)
  ) u_timebase (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_i),
    .load    (sec_load),
    .load_sec(bus_wdata),
    .sec_o   (run_sec),
    .ms_o    (run_ms)
  );

  rtc_bus_copy #(
    .SEC_W     (SEC_W),
    .MS_W      (MS_W),
    .COPY_TICKS(COPY_TICKS)
  ) u_copy (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_i),
    .load     (sec_load),
    .load_sec (bus_wdata),
    .sec_i    (run_sec),
    .ms_i     (run_ms),
    .ms_rd    (ms_rd),
    .busy_o   (busy),
    .bus_sec_o(bus_sec),
    .bus_ms_o (bus_ms),
    .shadow_o (shadow_sec)
  );

  rtc_alarm #(
    .SEC_W(SEC_W)
  ) u_alarm (
    .clk        (clk),
    .rst        (rst),
    .sec_i      (run_sec),
    .alarm_we   (bus_we && hit_alarm),
    .alarm_wdata(bus_wdata),
    .mask_we    (bus_we && hit_mask),
    .stat_we    (bus_we && hit_stat),
    .bits_wdata (bus_wdata[IRQ_W-1:0]),
    .alarm_o    (alarm_val),
    .mask_o     (mask_val),
    .status_o   (stat_val),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_val = '0;
    if (hit_busy)   rd_val = DATA_W'(busy);
    if (hit_sec)    rd_val = bus_sec;
    if (hit_shadow) rd_val = shadow_sec;
    if (hit_ms)     rd_val = DATA_W'(bus_ms);
    if (hit_alarm)  rd_val = alarm_val;
    if (hit_mask)   rd_val = DATA_W'(mask_val);
    if (hit_stat)   rd_val = DATA_W'(stat_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_val;
    end
  end

  AST_BUSY_WRITE_DROP: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit_sec && busy && !tick_i) |=> $stable(run_sec)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

// File: tb/rtc_sec_ms_tb_top.sv
module rtc_sec_ms_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint TPS = 32768;
  localparam longint MSPS = 1000;
  localparam longint COPY = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  longint      p_ticks = 0;
  longint      p_load = 0;
  logic [31:0] s_load = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_sec_ms dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .bus_rd(bus_rd), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
    p_ticks += n;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic model_copy(output logic [31:0] es, output logic [31:0] ems);
    longint c, tot;
    c = (p_ticks / COPY) * COPY;
    if (c > 0 && c - 1 >= p_load) begin
      tot = ((c - 1 - p_load) * MSPS) / TPS;
      es  = s_load + 32'(tot / MSPS);
      ems = 32'(tot % MSPS);
    end else begin
      es  = s_load;
      ems = '0;
    end
  endtask

  task automatic check_time(input string tag);
    logic [31:0] d, es, ems;
    model_copy(es, ems);
    bus_read(8'h04, d);
    chk_eq({tag, " R4 busy"}, d, (p_ticks % COPY == COPY - 1) ? 32'd1 : 32'd0);
    bus_read(8'h08, d);
    chk_eq({tag, " R3 seconds copy"}, d, es);
    bus_read(8'h10, d);
    chk_eq({tag, " R2 milliseconds copy"}, d, ems);
  endtask

  task automatic leave_busy();
    if (p_ticks % COPY == COPY - 1) run_ticks(1);
  endtask

  task automatic load_seconds(input logic [31:0] v);
    leave_busy();
    bus_write(8'h08, v);
    s_load = v;
    p_load = p_ticks;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(8'h04, d); chk_eq("R1 busy reset", d, 0);
    bus_read(8'h08, d); chk_eq("R1 seconds reset", d, 0);
    bus_read(8'h0C, d); chk_eq("R1 shadow reset", d, 0);
    bus_read(8'h10, d); chk_eq("R1 ms reset", d, 0);
    bus_read(8'h14, d); chk_eq("R1 alarm reset", d, 0);
    bus_read(8'h28, d); chk_eq("R1 mask reset", d, 0);
    bus_read(8'h2C, d); chk_eq("R1 status reset", d, 0);
    chk_eq("R1 irq reset", {31'b0, irq_o}, 0);
  endtask

  task automatic t_count();
    run_ticks(100); check_time("count100");
    run_ticks(5);   check_time("count105");
    run_ticks(3);   check_time("count108");
    run_ticks(1000); check_time("count1108");
  endtask

  task automatic t_load();
    logic [31:0] d;
    load_seconds(32'd41);
    bus_read(8'h08, d); chk_eq("R5 seconds after load", d, 41);
    bus_read(8'h10, d); chk_eq("R5 ms cleared by load", d, 0);
    run_ticks(32700); check_time("R2 before wrap");
    run_ticks(90);    check_time("R2 after wrap");
    bus_read(8'h08, d); chk_eq("R2 seconds incremented", d, 42);
  endtask

  task automatic t_busy();
    logic [31:0] d, es, ems;
    run_ticks(int'((COPY - 1 - (p_ticks % COPY) + COPY) % COPY));
    bus_read(8'h04, d); chk_eq("R4 busy high at phase 7", d, 1);
    bus_write(8'h08, 32'd555);
    model_copy(es, ems);
    bus_read(8'h08, d); chk_eq("R6 write during busy ignored", d, es);
    run_ticks(1);
    bus_read(8'h04, d); chk_eq("R4 busy low after copy", d, 0);
    check_time("R6 time intact");
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    load_seconds(32'd7);
    bus_read(8'h10, d);
    bus_read(8'h0C, d); chk_eq("R7 shadow latched", d, 7);
    load_seconds(32'd9);
    bus_read(8'h0C, d); chk_eq("R7 shadow unchanged by seconds write", d, 7);
    bus_read(8'h08, d); chk_eq("R5 seconds reload", d, 9);
    bus_read(8'h0C, d); chk_eq("R7 shadow unchanged by seconds read", d, 7);
    bus_read(8'h10, d);
    bus_read(8'h0C, d); chk_eq("R7 shadow relatched", d, 9);
  endtask

  task automatic t_alarm();
    logic [31:0] d;
    load_seconds(32'd100);
    bus_write(8'h14, 32'd101);
    bus_read(8'h14, d); chk_eq("R8 alarm readback", d, 101);
    run_ticks(32767); idle(2);
    bus_read(8'h2C, d); chk_eq("R8 no status before match", d, 0);
    run_ticks(1); idle(2);
    bus_read(8'h2C, d); chk_eq("R8 status on match", d, 1);
    chk_eq("R9 irq low while masked", {31'b0, irq_o}, 0);
    bus_write(8'h28, 32'h1); idle(2);
    chk_eq("R10 irq high after unmask", {31'b0, irq_o}, 1);
    bus_read(8'h28, d); chk_eq("R10 mask readback", d, 1);
    bus_write(8'h2C, 32'h1E); idle(1);
    bus_read(8'h2C, d); chk_eq("R9 write zero keeps bit", d, 1);
    chk_eq("R9 irq kept", {31'b0, irq_o}, 1);
    bus_write(8'h2C, 32'h1); idle(2);
    bus_read(8'h2C, d); chk_eq("R9 write one clears", d, 0);
    chk_eq("R10 irq falls", {31'b0, irq_o}, 0);
    run_ticks(50); idle(3);
    bus_read(8'h2C, d); chk_eq("R8 no reset while match persists", d, 0);
  endtask

  task automatic t_zero_alarm();
    logic [31:0] d;
    bus_write(8'h14, 32'd0);
    load_seconds(32'd0);
    run_ticks(20); idle(3);
    bus_read(8'h2C, d); chk_eq("R8 zero alarm disabled", d, 0);
    chk_eq("R8 irq stays low", {31'b0, irq_o}, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_read(8'h18, d); chk_eq("R11 offset 0x018 reads zero", d, 0);
    bus_read(8'h20, d); chk_eq("R11 offset 0x020 reads zero", d, 0);
    bus_read(8'h14, d);
    bus_addr = 8'h18;
    idle(3);
    chk_eq("R11 rdata holds without strobe", bus_rdata, 0);
    bus_write(8'h14, 32'd77);
    bus_read(8'h14, d); chk_eq("R11 read returns alarm", d, 77);
    idle(2);
    chk_eq("R11 rdata holds after read", bus_rdata, 77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_load();
    t_busy();
    t_shadow();
    t_alarm();
    t_zero_alarm();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule